// File: doc/BRIEF.md
# Neutral-Point Balance Dwell-Time Adjuster

This block sits between a three-level space-vector modulator and its switching-sequence generator. It trims the dwell times every modulation period so that the two DC-link capacitor voltages of a neutral-point-clamped inverter are pulled back toward equality. For each period it receives the upper and lower capacitor voltages (measured or estimated), the polarity of the neutral-point current seen while a medium vector is applied, and the nominal big, medium and zero dwell times. It returns the corrected dwell times three clock cycles later. Only one correction term is computed. It is proportional to the gain, to the capacitor voltage difference and to the nominal medium time. That term is moved from the medium vector to the zero vector, or from the zero vector to the medium vector, so the length of the period does not change.

Voltages are unsigned fixed point with `VF` fraction bits (default 4, so one LSB is 1/16 V). Dwell times are unsigned integers in timer ticks. The gain is unsigned fixed point with `GF` fraction bits (default 6). The gain is held in an internal register that firmware can overwrite through a one-cycle write strobe.

Top module: `np_dwell_balancer`

## Requirements
- R1: During and after reset, `out_valid` is 0, all three output times are 0 and the gain register holds 13 (0.203 with GF=6).
- R2: Every cycle with `in_valid`=1 produces exactly one cycle of `out_valid`=1 three clock edges later, in input order. `out_valid` is 0 in all other cycles. A gain write on its own produces no output.
- R3: `t_big_o` equals the `t_big` of the same sample, unchanged.
- R4: The shift magnitude is floor(gain × |vc_upper − vc_lower| × t_med / 2^(GF+VF)), computed with the gain register value in force when the sample is accepted.
- R5: Direction: when (vc_upper ≥ vc_lower) equals (`in_neg`=0), time moves from the medium vector to the zero vector. Otherwise it moves from the zero vector to the medium vector. Reversing either the voltage order or the current polarity reverses the direction.
- R6: When vc_upper equals vc_lower, the medium and zero times pass through unchanged.
- R7: `t_med_o` + `t_zero_o` equals `t_med` + `t_zero` of the same sample.
- R8: The amount moved is limited to the time available in the vector it is taken from. The medium and zero outputs therefore never go below 0, and the donor time saturates at exactly 0.
- R9: When `gain_we`=1, `gain_wdata` is loaded at that edge. A sample accepted in the same cycle still uses the old gain, and later samples use the new gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gain_we | input | 1 | Gain register write strobe |
| gain_wdata | input | GW | New gain value, GF fraction bits |
| in_valid | input | 1 | Sample accepted this cycle |
| vc_upper | input | VW | Upper capacitor voltage, VF fraction bits |
| vc_lower | input | VW | Lower capacitor voltage, VF fraction bits |
| in_neg | input | 1 | 1 when the neutral-point current is negative |
| t_big | input | TW | Nominal big-vector dwell time |
| t_med | input | TW | Nominal medium-vector dwell time |
| t_zero | input | TW | Nominal zero-vector dwell time |
| out_valid | output | 1 | Corrected times valid |
| t_big_o | output | TW | Big-vector dwell time, passed through |
| t_med_o | output | TW | Corrected medium-vector dwell time |
| t_zero_o | output | TW | Corrected zero-vector dwell time |

## Verification
A gain register update and the acceptance of a sample can happen in the same cycle. The block must then apply the old gain to that sample and the new gain only to the samples that follow. The bench provokes this on purpose. It issues a write together with a sample, follows it at once with another sample, and repeats this at random points in a random stream. Each result is judged against a bench model that updates its own gain copy only after it has computed the expected times for the coinciding sample. A change of gain from nonzero to zero makes any ordering error visible as a nonzero or zero shift.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;

  // direction in which the correction moves dwell time
  typedef enum logic {
    DIR_TO_MED  = 1'b0,
    DIR_TO_ZERO = 1'b1
  } shift_dir_e;

endpackage

// File: rtl/np_imbalance.sv
// Stage 1: capture sample, form |dV|, direction and |dV| * gain.
module np_imbalance
  import np_bal_pkg::*;
#(
  parameter int VW = 12,
  parameter int GW = 8,
  parameter int TW = 16,
  localparam int P1W = VW + GW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [VW-1:0]  vc_upper,
  input  logic [VW-1:0]  vc_lower,
  input  logic           in_neg,
  input  logic [TW-1:0]  t_big,
  input  logic [TW-1:0]  t_med,
  input  logic [TW-1:0]  t_zero,
  input  logic [GW-1:0]  gain,
  output logic           s1_valid,
  output logic [P1W-1:0] s1_prod,
  output shift_dir_e     s1_dir,
  output logic [TW-1:0]  s1_big,
  output logic [TW-1:0]  s1_med,
  output logic [TW-1:0]  s1_zero
);

  logic          upper_ge;
  logic [VW-1:0] abs_diff;
  shift_dir_e    dir_c;

  always_comb begin
    upper_ge = (vc_upper >= vc_lower);
    abs_diff = upper_ge ? (vc_upper - vc_lower) : (vc_lower - vc_upper);
    // sgn(dV) * sgn(In) == +1 -> take time from medium vector
    dir_c    = (upper_ge == !in_neg) ? DIR_TO_ZERO : DIR_TO_MED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_dir   <= DIR_TO_MED;
      s1_big   <= '0;
      s1_med   <= '0;
      s1_zero  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= P1W'(abs_diff) * P1W'(gain);
        s1_dir  <= dir_c;
        s1_big  <= t_big;
        s1_med  <= t_med;
        s1_zero <= t_zero;
      end
    end
  end

endmodule

// File: rtl/np_scale_mult.sv
// Stage 2: scale by the nominal medium time and drop fraction bits.
module np_scale_mult
  import np_bal_pkg::*;
#(
  parameter int P1W = 20,
  parameter int TW  = 16,
  parameter int SH  = 10,
  localparam int P2W = P1W + TW,
  localparam int MW  = P2W - SH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s1_valid,
  input  logic [P1W-1:0] s1_prod,
  input  shift_dir_e     s1_dir,
  input  logic [TW-1:0]  s1_big,
  input  logic [TW-1:0]  s1_med,
  input  logic [TW-1:0]  s1_zero,
  output logic           s2_valid,
  output logic [MW-1:0]  s2_mag,
  output shift_dir_e     s2_dir,
  output logic [TW-1:0]  s2_big,
  output logic [TW-1:0]  s2_med,
  output logic [TW-1:0]  s2_zero
);

  logic [P2W-1:0] full_prod;

  always_comb begin
    full_prod = P2W'(s1_prod) * P2W'(s1_med);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_mag   <= '0;
      s2_dir   <= DIR_TO_MED;
      s2_big   <= '0;
      s2_med   <= '0;
      s2_zero  <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_mag  <= full_prod[P2W-1:SH];
        s2_dir  <= s1_dir;
        s2_big  <= s1_big;
        s2_med  <= s1_med;
        s2_zero <= s1_zero;
      end
    end
  end

endmodule

// File: rtl/np_dwell_clamp.sv
// Stage 3: limit the shift to the donor time and apply it.
module np_dwell_clamp
  import np_bal_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s2_valid,
  input  logic [MW-1:0] s2_mag,
  input  shift_dir_e    s2_dir,
  input  logic [TW-1:0] s2_big,
  input  logic [TW-1:0] s2_med,
  input  logic [TW-1:0] s2_zero,
  output logic          out_valid,
  output logic [TW-1:0] t_big_o,
  output logic [TW-1:0] t_med_o,
  output logic [TW-1:0] t_zero_o
);

  logic [TW-1:0] donor;
  logic [TW-1:0] moved;
  logic [TW-1:0] med_n;
  logic [TW-1:0] zero_n;

  always_comb begin
    donor = (s2_dir == DIR_TO_ZERO) ? s2_med : s2_zero;
    if (s2_mag > MW'(donor)) moved = donor;
    else                     moved = s2_mag[TW-1:0];
    if (s2_dir == DIR_TO_ZERO) begin
      med_n  = s2_med - moved;
      zero_n = s2_zero + moved;
    end else begin
      med_n  = s2_med + moved;
      zero_n = s2_zero - moved;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      t_big_o   <= '0;
      t_med_o   <= '0;
      t_zero_o  <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        t_big_o  <= s2_big;
        t_med_o  <= med_n;
        t_zero_o <= zero_n;
      end
    end
  end

endmodule

// File: rtl/np_dwell_balancer.sv
module np_dwell_balancer
  import np_bal_pkg::*;
#(
  parameter int VW       = 12,
  parameter int VF       = 4,
  parameter int GW       = 8,
  parameter int GF       = 6,
  parameter int TW       = 16,
  parameter int GAIN_RST = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gain_we,
  input  logic [GW-1:0] gain_wdata,
  input  logic          in_valid,
  input  logic [VW-1:0] vc_upper,
  input  logic [VW-1:0] vc_lower,
  input  logic          in_neg,
  input  logic [TW-1:0] t_big,
  input  logic [TW-1:0] t_med,
  input  logic [TW-1:0] t_zero,
  output logic          out_valid,
  output logic [TW-1:0] t_big_o,
  output logic [TW-1:0] t_med_o,
  output logic [TW-1:0] t_zero_o
);

  localparam int SH  = GF + VF;
  localparam int P1W = VW + GW;
  localparam int MW  = P1W + TW - SH;

  logic [GW-1:0] gain_q;

  always_ff @(posedge clk) begin
    if (rst)          gain_q <= GW'(GAIN_RST);
    else if (gain_we) gain_q <= gain_wdata;
  end

  logic           s1_valid;
  logic [P1W-1:0] s1_prod;
  shift_dir_e     s1_dir;
  logic [TW-1:0]  s1_big, s1_med, s1_zero;

  logic           s2_valid;
  logic [MW-1:0]  s2_mag;
  shift_dir_e     s2_dir;
  logic [TW-1:0]  s2_big, s2_med, s2_zero;

  np_imbalance #(.VW(VW), .GW(GW), .TW(TW)) u_imb (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .vc_upper(vc_upper), .vc_lower(vc_lower), .in_neg(in_neg),
    .t_big(t_big), .t_med(t_med), .t_zero(t_zero), .gain(gain_q),
    .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_dir(s1_dir),
    .s1_big(s1_big), .s1_med(s1_med), .s1_zero(s1_zero)
  );

  np_scale_mult #(.P1W(P1W), .TW(TW), .SH(SH)) u_mul (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_prod(s1_prod),
    .s1_dir(s1_dir), .s1_big(s1_big), .s1_med(s1_med), .s1_zero(s1_zero),
    .s2_valid(s2_valid), .s2_mag(s2_mag), .s2_dir(s2_dir),
    .s2_big(s2_big), .s2_med(s2_med), .s2_zero(s2_zero)
  );

  np_dwell_clamp #(.TW(TW), .MW(MW)) u_clamp (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_mag(s2_mag),
    .s2_dir(s2_dir), .s2_big(s2_big), .s2_med(s2_med), .s2_zero(s2_zero),
    .out_valid(out_valid), .t_big_o(t_big_o), .t_med_o(t_med_o),
    .t_zero_o(t_zero_o)
  );

endmodule

// File: rtl/np_bal_chk.sv
module np_bal_chk #(
  parameter int VW = 12,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [VW-1:0] vc_upper,
  input logic [VW-1:0] vc_lower,
  input logic [TW-1:0] t_big,
  input logic [TW-1:0] t_med,
  input logic [TW-1:0] t_zero,
  input logic          out_valid,
  input logic [TW-1:0] t_big_o,
  input logic [TW-1:0] t_med_o,
  input logic [TW-1:0] t_zero_o
);

  logic [2:0]    v_sr;
  logic [2:0]    eq_sr;
  logic [TW-1:0] big_sr [3];
  logic [TW-1:0] med_sr [3];
  logic [TW:0]   sum_sr [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sr  <= '0;
      eq_sr <= '0;
      for (int i = 0; i < 3; i++) begin
        big_sr[i] <= '0;
        med_sr[i] <= '0;
        sum_sr[i] <= '0;
      end
    end else begin
      v_sr      <= {v_sr[1:0], in_valid};
      eq_sr     <= {eq_sr[1:0], (vc_upper == vc_lower)};
      big_sr[0] <= t_big;
      med_sr[0] <= t_med;
      sum_sr[0] <= {1'b0, t_med} + {1'b0, t_zero};
      for (int i = 1; i < 3; i++) begin
        big_sr[i] <= big_sr[i-1];
        med_sr[i] <= med_sr[i-1];
        sum_sr[i] <= sum_sr[i-1];
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sr[2]);

  assert_big_pass_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> t_big_o == big_sr[2]);

  assert_balanced_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && eq_sr[2]) |-> t_med_o == med_sr[2]);

  assert_sum_kept_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, t_med_o} + {1'b0, t_zero_o}) == sum_sr[2]);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, t_med_o} <= sum_sr[2] && {1'b0, t_zero_o} <= sum_sr[2]));

endmodule

bind np_dwell_balancer np_bal_chk #(.VW(VW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .vc_upper(vc_upper), .vc_lower(vc_lower),
  .t_big(t_big), .t_med(t_med), .t_zero(t_zero),
  .out_valid(out_valid), .t_big_o(t_big_o), .t_med_o(t_med_o),
  .t_zero_o(t_zero_o)
);

// File: tb/test_np_dwell_balancer.sv
`timescale 1ns/1ps
module test_np_dwell_balancer;

  localparam int VW = 12, VF = 4, GW = 8, GF = 6, TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gain_we = 1'b0;
  logic [GW-1:0] gain_wdata = '0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] vc_upper = '0, vc_lower = '0;
  logic          in_neg = 1'b0;
  logic [TW-1:0] t_big = '0, t_med = '0, t_zero = '0;
  logic          out_valid;
  logic [TW-1:0] t_big_o, t_med_o, t_zero_o;

  always #5 clk = ~clk;

  np_dwell_balancer i_np_dwell_balancer (
    .clk(clk), .rst(rst), .gain_we(gain_we), .gain_wdata(gain_wdata),
    .in_valid(in_valid), .vc_upper(vc_upper), .vc_lower(vc_lower),
    .in_neg(in_neg), .t_big(t_big), .t_med(t_med), .t_zero(t_zero),
    .out_valid(out_valid), .t_big_o(t_big_o), .t_med_o(t_med_o),
    .t_zero_o(t_zero_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int model_gain = 13;

  typedef struct {
    int    big, med, zero, sent;
    string tag;
  } exp_t;
  exp_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // R4 R5 R6 R8 reference
  function automatic void model(input int vu, input int vl, input bit neg,
                                input int tm, input int tz, input int g,
                                output int m, output int z, output string tag);
    longint ad, mag, mv;
    bit to_zero;
    ad      = (vu >= vl) ? vu - vl : vl - vu;
    mag     = (longint'(g) * ad * tm) >>> (GF + VF);
    to_zero = ((vu >= vl) == (neg == 1'b0));
    if (to_zero) begin
      mv = (mag > tm) ? tm : mag;
      m = tm - int'(mv); z = tz + int'(mv);
    end else begin
      mv = (mag > tz) ? tz : mag;
      m = tm + int'(mv); z = tz - int'(mv);
    end
    if (vu == vl)                                   tag = "R6";
    else if (mag > (to_zero ? tm : tz))             tag = "R8";
    else                                            tag = "R4/R5";
  endfunction

  task automatic send(input int vu, input int vl, input bit neg,
                      input int tb, input int tm, input int tz,
                      input bit gw, input int gd);
    exp_t e;
    int m, z;
    string tg;
    @(negedge clk);
    vc_upper = VW'(vu); vc_lower = VW'(vl); in_neg = neg;
    t_big = TW'(tb); t_med = TW'(tm); t_zero = TW'(tz);
    in_valid = 1'b1;
    gain_we = gw; gain_wdata = GW'(gd);
    model(vu, vl, neg, tm, tz, model_gain, m, z, tg);
    e.big = tb; e.med = m; e.zero = z; e.sent = cyc; e.tag = tg;
    if (gw) begin e.tag = {tg, " R9"}; model_gain = gd; end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; gain_we = 1'b0;
    end
  endtask

  task automatic write_gain(input int gd);
    @(negedge clk);
    in_valid = 1'b0; gain_we = 1'b1; gain_wdata = GW'(gd);
    model_gain = gd;
  endtask

  // monitor: R2 R3 R7 and the value checks
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc - e.sent == 3, "R2 latency", cyc - e.sent, 3);
        check(int'(t_big_o) == e.big, "R3 big pass", t_big_o, e.big);
        check(int'(t_med_o) == e.med, {e.tag, " medium"}, t_med_o, e.med);
        check(int'(t_zero_o) == e.zero, {e.tag, " zero"}, t_zero_o, e.zero);
        check(int'(t_med_o) + int'(t_zero_o) == e.med + e.zero, "R7 sum",
              int'(t_med_o) + int'(t_zero_o), e.med + e.zero);
      end
    end
  end

  initial begin : watchdog
    #(10 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(t_med_o == '0 && t_zero_o == '0 && t_big_o == '0, "R1 outputs zero",
          t_med_o, 0);

    // R1 default gain + R4: 1 V imbalance, 13*16*1000>>10 = 203
    send(3216, 3200, 1'b0, 3000, 1000, 6000, 1'b0, 0);
    // R5 polarity flips
    send(3216, 3200, 1'b1, 3000, 1000, 6000, 1'b0, 0);
    send(3200, 3216, 1'b0, 3000, 1000, 6000, 1'b0, 0);
    send(3200, 3216, 1'b1, 3000, 1000, 6000, 1'b0, 0);
    // R6 balanced
    send(2500, 2500, 1'b0, 100, 4000, 50, 1'b0, 0);
    // R8 saturation both ways
    send(4000, 0, 1'b0, 10, 500, 100, 1'b0, 0);
    send(4000, 0, 1'b1, 10, 500, 100, 1'b0, 0);
    send(0, 4095, 1'b0, 10, 7, 0, 1'b0, 0);
    idle(5);
    // R2 gain write alone gives no output
    write_gain(40);
    idle(5);
    send(3300, 3200, 1'b0, 1, 2000, 3000, 1'b0, 0);
    // R9 coinciding write: old gain here, zero gain next
    send(3300, 3200, 1'b1, 1, 2000, 3000, 1'b1, 0);
    send(3300, 3200, 1'b1, 1, 2000, 3000, 1'b0, 0);
    send(3300, 3200, 1'b0, 2, 2000, 3000, 1'b1, 26);
    send(3300, 3200, 1'b0, 2, 2000, 3000, 1'b0, 0);
    idle(5);

    // random stream with occasional coinciding gain writes
    for (int i = 0; i < 600; i++) begin
      int base, vu, vl, gd;
      bit gw;
      base = 2800 + int'($urandom_range(800));
      vu = base + int'($urandom_range(160)) - 80;
      vl = base + int'($urandom_range(160)) - 80;
      if ($urandom_range(9) == 0) vl = vu;
      gw = ($urandom_range(11) == 0);
      gd = int'($urandom_range(255));
      send(vu, vl, 1'($urandom_range(1)), int'($urandom_range(20000)),
           int'($urandom_range(20000)), int'($urandom_range(20000)), gw, gd);
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(8);
    check(q.size() == 0, "R2 all samples returned", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule